// File: doc/BRIEF.md
# Serial Register-Pointer Target for a Banked Port Expander

This block is the byte-level front end of a two-wire serial target that sits in front of a port expander's register file. A bit-level receiver, outside this block, turns the bus into events: a START (or repeated START) pulse, a STOP pulse, a received byte with a valid pulse, and, during reads, the master's acknowledge for each byte the target has sent. The block checks the 7-bit target address, whose upper four bits are fixed at `0100` and whose lower three come from the `addr_sel` pins. It takes the first byte after a write address as a command byte holding a 6-bit register pointer and an auto-step flag. It then passes data bytes to the register file as write strobes, or fetches bytes from it as read strobes. For every byte it handles, it raises an acknowledge strobe telling the bit-level logic whether to drive the acknowledge.

The register space holds five groups of five banks. A group sits at pointer bits [5:3] = 0..4 and a bank at pointer bits [2:0] = 0..4. Auto-step moves only the bank field, so a burst cycles through the banks of one group and never leaves it. If the bus is held low too long, the interface returns to idle. This timeout can be switched off. Event streams are plain valid pulses with no back-pressure, because the target never stalls. Consecutive events (`rx_valid`, `mack_valid`) must be at least two clock cycles apart. A real serial bus always meets this, since a byte takes many clocks.

Top module: `xpd_serial_target`

## Requirements
- R1: After reset, the state is idle, the pointer is 0x00 and auto-step is off. `ack_stb`, `reg_wr`, `reg_rd` and `tx_valid` are low, and `reg_addr` is 0x00.
- R2: After a START, the first byte is an address. If bits [7:1] equal {0100, addr_sel}, the cycle after `rx_valid` shows `ack_stb`=1 with `ack_drive`=1. Otherwise it shows `ack_stb`=1 with `ack_drive`=0, and every later byte or master acknowledge is ignored (no strobe) until the next START.
- R3: The byte after a matching write address (bit 0 = 0) is the command byte. Bits [5:0] load the pointer, bit 7 sets auto-step, and bit 6 has no effect. It is acknowledged.
- R4: Each later data byte gives, one cycle after `rx_valid`, `reg_wr`=1 with `reg_addr` = pointer and `reg_wdata` = the byte, together with an acknowledge (`ack_drive`=1). Any number of data bytes may follow.
- R5: With auto-step on, the pointer's bits [2:0] advance by one after each data byte written or read. Value 4 wraps to 0, value 7 wraps to 0, and bits [5:3] never change. With auto-step off, the pointer holds.
- R6: A pointer whose bits [5:3] or bits [2:0] exceed 4 is unimplemented. Writes to it give no `reg_wr`, reads from it give no `reg_rd` and return `tx_byte`=0x00, and the target still acknowledges and still auto-steps.
- R7: A matching read address (bit 0 = 1) gives `reg_rd` with `reg_addr` = pointer one cycle after `rx_valid`, and `tx_valid` with `tx_byte` = `reg_rdata` one cycle later. A master acknowledge (`mack_ok`=1) repeats this fetch, counting from `mack_valid`. A master not-acknowledge stops fetching, and the target ignores the bus until the next START.
- R8: A repeated START keeps the pointer, so a read after a command-only write starts at the commanded pointer.
- R9: A STOP returns the target to idle, where bytes give no strobe until a START.
- R10: With `tmo_en`=1, `bus_low` held for TMO_CYCLES consecutive cycles returns the interface to idle. Fewer cycles, or `tmo_en`=0, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 3 | Low three bits of the target address |
| tmo_en | input | 1 | Enables the stuck-bus timeout |
| bus_low | input | 1 | High while either bus line is low |
| ev_start | input | 1 | START or repeated START pulse |
| ev_stop | input | 1 | STOP pulse |
| rx_valid | input | 1 | A byte from the master is complete |
| rx_byte | input | 8 | Received byte |
| mack_valid | input | 1 | Master acknowledge slot after a sent byte |
| mack_ok | input | 1 | 1 = master acknowledged, 0 = not acknowledged |
| ack_stb | output | 1 | Acknowledge-phase strobe for a received byte |
| ack_drive | output | 1 | With ack_stb: 1 = acknowledge, 0 = leave released |
| reg_addr | output | 6 | Register pointer |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read data, same cycle as reg_rd |
| tx_valid | output | 1 | Byte to send is ready |
| tx_byte | output | 8 | Byte to send |

## Verification
The bench builds the block with TMO_CYCLES = 16 and the default five groups of five banks. The short limit lets the bench hold the bus low for exactly one cycle fewer than the limit and for exactly the limit, and observe the difference through the next byte's acknowledge. The full-size register geometry puts the bank wrap from 4 to 0, the wrap through the unimplemented offsets 5 to 7, and the pointers beyond group 4 within direct reach of short bursts.

// File: rtl/xpd_tgt_pkg.sv
package xpd_tgt_pkg;
  localparam int PTR_W   = 6;
  localparam int BANK_W  = 3;
  localparam int AI_BIT  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } tgt_state_e;
endpackage

// File: rtl/xpd_addr_match.sv
module xpd_addr_match #(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic [2:0] sel,
  input  logic [7:0] byte_in,
  output logic       hit,
  output logic       rnw
);
  // Address byte layout: [7:4] fixed, [3:1] pin-selected, [0] direction.
  assign hit = (byte_in[7:4] == ADDR_HI) && (byte_in[3:1] == sel);
  assign rnw = byte_in[0];
endmodule

// File: rtl/xpd_ptr_unit.sv
module xpd_ptr_unit
  import xpd_tgt_pkg::*;
#(
  parameter int GROUPS = 5,
  parameter int BANKS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr,
  output logic             ok
);
  localparam int GRP_W = PTR_W - BANK_W;
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);

  logic [BANK_W-1:0] bank;
  logic [GRP_W-1:0]  grp;
  assign bank = ptr[BANK_W-1:0];
  assign grp  = ptr[PTR_W-1:BANK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (step) begin
      // only the bank field moves; the group field is never touched
      ptr[BANK_W-1:0] <= (bank == LAST_BANK) ? '0 : bank + 1'b1;
    end
  end

  assign ok = (int'(grp) < GROUPS) && (int'(bank) < BANKS);

  assert_step_keeps_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr[PTR_W-1:BANK_W] == $past(ptr[PTR_W-1:BANK_W])));

  assert_last_bank_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && bank == LAST_BANK) |=> (ptr[BANK_W-1:0] == '0));
endmodule

// File: rtl/xpd_bus_timeout.sv
module xpd_bus_timeout #(
  parameter int TMO_CYCLES = 3_125_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bus_low,
  output logic fire
);
  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYCLES);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || !bus_low) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign fire = en && bus_low && (cnt == LAST);

  assert_fire_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(bus_low && en));
endmodule

// File: rtl/xpd_serial_target.sv
module xpd_serial_target
  import xpd_tgt_pkg::*;
#(
  parameter logic [3:0] ADDR_HI    = 4'b0100,
  parameter int         GROUPS     = 5,
  parameter int         BANKS      = 5,
  parameter int         TMO_CYCLES = 3_125_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr_sel,
  input  logic             tmo_en,
  input  logic             bus_low,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             mack_valid,
  input  logic             mack_ok,
  output logic             ack_stb,
  output logic             ack_drive,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_wr,
  output logic [7:0]       reg_wdata,
  output logic             reg_rd,
  input  logic [7:0]       reg_rdata,
  output logic             tx_valid,
  output logic [7:0]       tx_byte
);
  tgt_state_e       state;
  logic             ai_q;
  logic             wr_pend;
  logic             rd_pend;
  logic [7:0]       wdata_q;
  logic             fire;
  logic             hit;
  logic             rnw;
  logic             ptr_load;
  logic             ptr_step;
  logic             ptr_ok;
  logic [PTR_W-1:0] ptr;
  logic             quiet;

  xpd_addr_match #(.ADDR_HI(ADDR_HI)) u_match (
    .sel     (addr_sel),
    .byte_in (rx_byte),
    .hit     (hit),
    .rnw     (rnw)
  );

  xpd_bus_timeout #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tmo_en),
    .bus_low (bus_low),
    .fire    (fire)
  );

  // no bus event overrides the byte in this cycle
  assign quiet    = !fire && !ev_start && !ev_stop;
  assign ptr_load = quiet && rx_valid && (state == ST_CMD);
  assign ptr_step = ai_q && (wr_pend || rd_pend);

  xpd_ptr_unit #(.GROUPS(GROUPS), .BANKS(BANKS)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (rx_byte[PTR_W-1:0]),
    .step     (ptr_step),
    .ptr      (ptr),
    .ok       (ptr_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ai_q      <= 1'b0;
      wr_pend   <= 1'b0;
      rd_pend   <= 1'b0;
      wdata_q   <= '0;
      ack_stb   <= 1'b0;
      ack_drive <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
    end else begin
      ack_stb  <= 1'b0;
      wr_pend  <= 1'b0;
      rd_pend  <= 1'b0;
      tx_valid <= 1'b0;
      if (rd_pend) begin
        tx_valid <= 1'b1;
        tx_byte  <= ptr_ok ? reg_rdata : 8'h00;
      end
      if (fire) begin
        state <= ST_IDLE;
      end else if (ev_start) begin
        state <= ST_ADDR;
      end else if (ev_stop) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_ADDR: if (rx_valid) begin
            ack_stb   <= 1'b1;
            ack_drive <= hit;
            if (!hit)     state <= ST_HOLD;
            else if (rnw) begin
              state   <= ST_RDATA;
              rd_pend <= 1'b1;
            end else      state <= ST_CMD;
          end
          ST_CMD: if (rx_valid) begin
            ack_stb   <= 1'b1;
            ack_drive <= 1'b1;
            ai_q      <= rx_byte[AI_BIT];
            state     <= ST_WDATA;
          end
          ST_WDATA: if (rx_valid) begin
            ack_stb   <= 1'b1;
            ack_drive <= 1'b1;
            wdata_q   <= rx_byte;
            wr_pend   <= 1'b1;
          end
          ST_RDATA: if (mack_valid) begin
            if (mack_ok) rd_pend <= 1'b1;
            else         state   <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr  = ptr;
  assign reg_wdata = wdata_q;
  assign reg_wr    = wr_pend && ptr_ok;
  assign reg_rd    = rd_pend && ptr_ok;

  assert_ack_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> $past(rx_valid));

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd, tx_valid && reg_rd}));

  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && quiet) |=> !ack_stb && !reg_wr && !reg_rd);

  assert_tx_after_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(ack_stb) || $past(mack_valid, 2)));
endmodule

// File: tb/tb_xpd_serial_target.sv
module tb_xpd_serial_target;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr_sel = 3'b101;
  logic       tmo_en = 1'b0;
  logic       bus_low = 1'b0;
  logic       ev_start = 1'b0;
  logic       ev_stop = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       mack_valid = 1'b0;
  logic       mack_ok = 1'b0;
  logic       ack_stb, ack_drive, reg_wr, reg_rd, tx_valid;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, tx_byte;

  always #4 clk = ~clk;

  xpd_serial_target #(.TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .tmo_en(tmo_en),
    .bus_low(bus_low), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .mack_valid(mack_valid),
    .mack_ok(mack_ok), .ack_stb(ack_stb), .ack_drive(ack_drive),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_byte(tx_byte)
  );

  // register file stand-in: a fixed function of the address
  function automatic logic [7:0] rf(input logic [5:0] a);
    return {a, 2'b01} ^ 8'hA5;
  endfunction
  assign reg_rdata = rf(reg_addr);

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  // reference model state: 0 idle 1 addr 2 cmd 3 write 4 read 5 hold
  int       m_st = 0;
  bit [5:0] m_ptr = 0;
  bit       m_ai = 0;

  // expectations for the next sample and for the one after
  bit       e_ack, e_drv, e_wr, e_rd, e_tx, n_tx;
  bit [5:0] e_addr;
  bit [7:0] e_wd, e_txb, n_txb;

  task automatic chk(input bit good, input string what, input int act, input int exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_ok(input bit [5:0] p);
    return (p[5:3] <= 3'd4) && (p[2:0] <= 3'd4);
  endfunction

  function automatic bit [5:0] m_next(input bit [5:0] p);
    bit [2:0] b = (p[2:0] == 3'd4) ? 3'd0 : p[2:0] + 3'd1;
    return {p[5:3], b};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(ack_stb === e_ack, "ack_stb", ack_stb, e_ack);
    if (e_ack) chk(ack_drive === e_drv, "ack_drive", ack_drive, e_drv);
    chk(reg_wr === e_wr, "reg_wr", reg_wr, e_wr);
    chk(reg_rd === e_rd, "reg_rd", reg_rd, e_rd);
    if (e_wr || e_rd) chk(reg_addr === e_addr, "reg_addr", reg_addr, e_addr);
    if (e_wr) chk(reg_wdata === e_wd, "reg_wdata", reg_wdata, e_wd);
    chk(tx_valid === e_tx, "tx_valid", tx_valid, e_tx);
    if (e_tx) chk(tx_byte === e_txb, "tx_byte", tx_byte, e_txb);
    e_tx = n_tx; e_txb = n_txb; n_tx = 0;
    e_ack = 0; e_wr = 0; e_rd = 0;
    ev_start = 0; ev_stop = 0; rx_valid = 0; mack_valid = 0;
  endtask

  task automatic m_fetch();
    e_rd = m_ok(m_ptr); e_addr = m_ptr;
    n_tx = 1; n_txb = m_ok(m_ptr) ? rf(m_ptr) : 8'h00;
    if (m_ai) m_ptr = m_next(m_ptr);
  endtask

  task automatic do_start();
    ev_start = 1; m_st = 1; step(); step();
  endtask

  task automatic do_stop();
    ev_stop = 1; m_st = 0; step(); step();
  endtask

  task automatic do_byte(input bit [7:0] b);
    rx_valid = 1; rx_byte = b;
    case (m_st)
      1: begin
        e_ack = 1;
        if (b[7:1] == {4'b0100, addr_sel}) begin
          e_drv = 1;
          if (b[0]) begin m_st = 4; m_fetch(); end
          else m_st = 2;
        end else begin
          e_drv = 0; m_st = 5;
        end
      end
      2: begin e_ack = 1; e_drv = 1; m_ptr = b[5:0]; m_ai = b[7]; m_st = 3; end
      3: begin
        e_ack = 1; e_drv = 1;
        e_wr = m_ok(m_ptr); e_addr = m_ptr; e_wd = b;
        if (m_ai) m_ptr = m_next(m_ptr);
      end
      default: ;
    endcase
    step(); step();
  endtask

  task automatic do_mack(input bit ok);
    mack_valid = 1; mack_ok = ok;
    if (m_st == 4) begin
      if (ok) m_fetch(); else m_st = 5;
    end
    step(); step();
  endtask

  task automatic hold_low(input int n);
    bus_low = 1;
    for (int i = 0; i < n; i++) step();
    bus_low = 0;
    if (tmo_en && n >= TMO) m_st = 0;
    step();
  endtask

  initial begin
    e_ack = 0; e_wr = 0; e_rd = 0; e_tx = 0; n_tx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk(ack_stb === 0 && reg_wr === 0 && reg_rd === 0 && tx_valid === 0, "idle strobes", ack_stb, 0);
    chk(reg_addr === 6'h00, "reset pointer", reg_addr, 0);
    rst_n = 1;
    step();

    tag = "R2"; // wrong address is refused; following byte ignored
    do_start(); do_byte(8'h4C); do_byte(8'h88); do_byte(8'h11); do_stop();

    tag = "R4"; // write burst with auto-step, wrapping bank 4 to 0 (R5)
    do_start(); do_byte(8'h4A); do_byte(8'h88);
    for (int i = 0; i < 6; i++) do_byte(8'h30 + 8'(i));
    do_stop();

    tag = "R3"; // bit 6 ignored, auto-step off
    do_start(); do_byte(8'h4A); do_byte(8'h52); do_byte(8'hE1); do_byte(8'hE2); do_stop();

    tag = "R6"; // unimplemented banks 5..7 step through to bank 0
    do_start(); do_byte(8'h4A); do_byte(8'h85);
    for (int i = 0; i < 4; i++) do_byte(8'h70 + 8'(i));
    tag = "R6_group"; // group 5 has nothing behind it
    ev_start = 1; m_st = 1; step(); step();
    do_byte(8'h4A); do_byte(8'h2A); do_byte(8'h99);
    do_stop();

    tag = "R8"; // command then repeated START then read burst (R7, R5)
    do_start(); do_byte(8'h4A); do_byte(8'h9B);
    do_start(); do_byte(8'h4B);
    tag = "R7";
    for (int i = 0; i < 5; i++) do_mack(1'b1);
    do_mack(1'b0);
    do_mack(1'b1); do_byte(8'h22);
    do_stop();

    tag = "R7_unimpl"; // read from bank 6 returns zero, steps into 7 then 0
    do_start(); do_byte(8'h4A); do_byte(8'h86);
    do_start(); do_byte(8'h4B);
    do_mack(1'b1); do_mack(1'b1); do_mack(1'b0);
    do_stop();

    tag = "R9"; // after STOP a byte is ignored
    do_byte(8'h4A); do_byte(8'h00);

    tag = "R2_sel"; // a different select value matches a different address
    addr_sel = 3'b010;
    do_start(); do_byte(8'h4A); do_stop();
    do_start(); do_byte(8'h44); do_byte(8'h03); do_byte(8'h5C); do_stop();

    tag = "R10"; // one cycle short of the limit, then the full limit
    tmo_en = 1;
    do_start(); do_byte(8'h44);
    hold_low(TMO - 1);
    do_byte(8'h01); do_byte(8'h66);
    hold_low(TMO);
    do_byte(8'h67);
    tag = "R10_off";
    tmo_en = 0;
    do_start(); do_byte(8'h44);
    hold_low(3 * TMO);
    do_byte(8'h02); do_byte(8'h68);
    do_stop();

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule